// File: doc/BRIEF.md
# Tiled Depth Surface Address Generator

This unit maps a pixel coordinate onto a byte offset inside a depth surface whose memory layout is always tiled. Each coordinate is first reduced to a block index: the tile row times the number of tiles across the surface, plus the tile column. The block index then supplies the upper offset bits. One bank bit picks the 2 KB half of a 4 KB tile pair. The low eleven bits interleave coordinate bits in a fixed pattern, and that pattern differs between 2-byte and 4-byte pixels.

A linear override skips the tiling and returns the plain row-major offset. The base-address add, the memory access itself and any clipping belong to the caller. The result and a valid flag come out of one register stage, so the unit can sit inline in a pixel pipeline and accept a new coordinate every cycle.

Top module: `dtile_addr_gen`

## Requirements
- R1: While `rst` is high at a rising clock edge, `ofs_valid` and `ofs` are cleared to zero on that edge.
- R2: `ofs_valid` equals the `pix_valid` value sampled at the previous rising edge, which gives a latency of one cycle.
- R3: A cycle with `pix_valid` low leaves `ofs` unchanged.
- R4: With `lin_en` high, `ofs` = (x*bpp + y*pitch) mod 2^26, where bpp is the pixel size in bytes.
- R5: `pix_sz` = 0 selects 2-byte pixels and `pix_sz` = 1 selects 4-byte pixels, for both the tiled and the linear offsets.
- R6: With tiling active, the block index is b = (y>>4)*(pitch>>8) + (x>>6) for 2-byte pixels, and b = ((y & 0x7FF)>>4)*(pitch>>7) + (x>>5) for 4-byte pixels.
- R7: With tiling active, ofs[25:12] holds b>>1, truncated to fit.
- R8: With tiling active, ofs[11] equals b[0] when the tiles-per-row value (pitch>>8 for 2-byte pixels, pitch>>7 for 4-byte pixels) is odd. When that value is even, ofs[11] equals b[0] XOR y[4].
- R9: For 2-byte tiled pixels the low bits are: ofs[10:9]=y[3:2], ofs[8]=x[3], ofs[7:6]=x[5:4], ofs[5]=x[2], ofs[4]=y[1], ofs[3]=x[1], ofs[2]=y[0], ofs[1]=x[0], ofs[0]=0.
- R10: For 4-byte tiled pixels the low bits are: ofs[10:9]=y[3:2], ofs[8]=x[2], ofs[7:6]=x[4:3], ofs[5]=y[1], ofs[4]=x[1], ofs[3]=y[0], ofs[2]=x[0], ofs[1:0]=0. y[11] has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pix_valid | input | 1 | The coordinate inputs are valid this cycle |
| pix_x | input | 12 | Pixel column |
| pix_y | input | 12 | Pixel row |
| pitch | input | 16 | Surface row pitch in bytes |
| pix_sz | input | 1 | Pixel size: 0 = 2 bytes, 1 = 4 bytes |
| lin_en | input | 1 | Use the linear row-major offset instead of tiling |
| ofs_valid | output | 1 | `ofs` holds a new result |
| ofs | output | 26 | Byte offset within the surface |

## Verification
The bench targets the bank bit with pitches whose tiles-per-row value is odd and with pitches where it is even. A design that always applied the y[4] swap, or never applied it, would place every other tile row in the wrong 2 KB half. Directed points cross the 16-row and 32/64-column tile boundaries, where a wrong shift amount in the block index moves whole tiles. A pair of 4-byte coordinates that differ only in y[11] must give the same offset; a design that kept that bit would wrap into a far-away tile. Random coordinates mixed with idle cycles and reset catch swapped interleave bits, a swapped pixel-size encoding, and an offset that drifts while no input is valid.

// File: rtl/dtile_pkg.sv
package dtile_pkg;
  typedef enum logic {
    PIX_2B = 1'b0,
    PIX_4B = 1'b1
  } pix_size_e;

  localparam int unsigned TILE_LOW_BITS = 11;
endpackage

// File: rtl/dtile_block.sv
module dtile_block
  import dtile_pkg::*;
#(
  parameter int unsigned X_W     = 12,
  parameter int unsigned Y_W     = 12,
  parameter int unsigned P_W     = 16,
  parameter int unsigned Y4_BITS = 11,
  parameter int unsigned B_W     = 18
) (
  input  logic [X_W-1:0] x,
  input  logic [Y_W-1:0] y,
  input  logic [P_W-1:0] pitch,
  input  pix_size_e      sz,
  output logic [B_W-1:0] blk,
  output logic           tpr_odd
);
  localparam int unsigned YROW_W = Y_W - 4;
  localparam int unsigned TPR_W  = P_W - 7;
  localparam logic [YROW_W-1:0] Y4_MASK =
    YROW_W'((64'd1 << (Y4_BITS - 4)) - 64'd1);

  logic [TPR_W-1:0]  tpr;
  logic [YROW_W-1:0] yrow;
  logic [X_W-1:0]    xcol;

  always_comb begin
    if (sz == PIX_4B) begin
      tpr  = pitch[P_W-1:7];
      yrow = y[Y_W-1:4] & Y4_MASK;
      xcol = x >> 5;
    end else begin
      tpr  = {1'b0, pitch[P_W-1:8]};
      yrow = y[Y_W-1:4];
      xcol = x >> 6;
    end
    tpr_odd = tpr[0];
    blk     = B_W'(yrow) * B_W'(tpr) + B_W'(xcol);
  end
endmodule

// File: rtl/dtile_swizzle.sv
module dtile_swizzle
  import dtile_pkg::*;
#(
  parameter int unsigned X_W = 12,
  parameter int unsigned Y_W = 12,
  parameter int unsigned B_W = 18,
  parameter int unsigned O_W = 26
) (
  input  logic [X_W-1:0] x,
  input  logic [Y_W-1:0] y,
  input  logic [B_W-1:0] blk,
  input  logic           tpr_odd,
  input  pix_size_e      sz,
  output logic [O_W-1:0] ofs
);
  localparam int unsigned FULL_W = B_W - 1 + 1 + TILE_LOW_BITS;

  logic [TILE_LOW_BITS-1:0] low2, low4, low_sel;
  logic                     bank;
  logic [FULL_W-1:0]        full;

  always_comb begin
    low2 = {y[3:2], x[3], x[5:4], x[2], y[1], x[1], y[0], x[0], 1'b0};
    low4 = {y[3:2], x[2], x[4:3], y[1], x[1], y[0], x[0], 2'b00};
    low_sel = (sz == PIX_4B) ? low4 : low2;
    bank = blk[0] ^ (~tpr_odd & y[4]);
    full = {blk[B_W-1:1], bank, low_sel};
    ofs  = O_W'(full);
  end
endmodule

// File: rtl/dtile_linear.sv
module dtile_linear
  import dtile_pkg::*;
#(
  parameter int unsigned X_W = 12,
  parameter int unsigned Y_W = 12,
  parameter int unsigned P_W = 16,
  parameter int unsigned O_W = 26
) (
  input  logic [X_W-1:0] x,
  input  logic [Y_W-1:0] y,
  input  logic [P_W-1:0] pitch,
  input  pix_size_e      sz,
  output logic [O_W-1:0] ofs
);
  localparam int unsigned SUM_W = Y_W + P_W + 1;

  logic [SUM_W-1:0] col_bytes, row_bytes, sum;

  always_comb begin
    col_bytes = (sz == PIX_4B) ? SUM_W'({x, 2'b00}) : SUM_W'({x, 1'b0});
    row_bytes = SUM_W'(y) * SUM_W'(pitch);
    sum       = col_bytes + row_bytes;
    ofs       = O_W'(sum);
  end
endmodule

// File: rtl/dtile_addr_gen.sv
module dtile_addr_gen
  import dtile_pkg::*;
#(
  parameter int unsigned X_W     = 12,
  parameter int unsigned Y_W     = 12,
  parameter int unsigned P_W     = 16,
  parameter int unsigned O_W     = 26,
  parameter int unsigned Y4_BITS = 11
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           pix_valid,
  input  logic [X_W-1:0] pix_x,
  input  logic [Y_W-1:0] pix_y,
  input  logic [P_W-1:0] pitch,
  input  logic           pix_sz,
  input  logic           lin_en,
  output logic           ofs_valid,
  output logic [O_W-1:0] ofs
);
  localparam int unsigned B_W = (Y_W - 4) + (P_W - 7) + 1;

  pix_size_e      sz;
  logic [B_W-1:0] blk;
  logic           tpr_odd;
  logic [O_W-1:0] tiled_ofs, linear_ofs, next_ofs;

  assign sz = pix_size_e'(pix_sz);

  dtile_block #(
    .X_W(X_W), .Y_W(Y_W), .P_W(P_W), .Y4_BITS(Y4_BITS), .B_W(B_W)
  ) u_block (
    .x(pix_x), .y(pix_y), .pitch(pitch), .sz(sz),
    .blk(blk), .tpr_odd(tpr_odd)
  );

  dtile_swizzle #(
    .X_W(X_W), .Y_W(Y_W), .B_W(B_W), .O_W(O_W)
  ) u_swz (
    .x(pix_x), .y(pix_y), .blk(blk), .tpr_odd(tpr_odd), .sz(sz),
    .ofs(tiled_ofs)
  );

  dtile_linear #(
    .X_W(X_W), .Y_W(Y_W), .P_W(P_W), .O_W(O_W)
  ) u_lin (
    .x(pix_x), .y(pix_y), .pitch(pitch), .sz(sz),
    .ofs(linear_ofs)
  );

  assign next_ofs = lin_en ? linear_ofs : tiled_ofs;

  always_ff @(posedge clk) begin
    if (rst) begin
      ofs_valid <= 1'b0;
      ofs       <= '0;
    end else begin
      ofs_valid <= pix_valid;
      if (pix_valid) ofs <= next_ofs;
    end
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!ofs_valid && ofs == '0)); // R1

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    pix_valid |=> ofs_valid); // R2

  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
    !pix_valid |=> !ofs_valid); // R2

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !pix_valid |=> $stable(ofs)); // R3

  AST_TILE2_LSB_ZERO: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && !lin_en && !pix_sz) |=> (ofs[0] == 1'b0)); // R9

  AST_TILE4_LSB_ZERO: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && !lin_en && pix_sz) |=> (ofs[1:0] == 2'b00)); // R10

  AST_TILE_ROW_BITS: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && !lin_en) |=> (ofs[10:9] == $past(pix_y[3:2]))); // R9
endmodule

// File: tb/tb_dtile_addr_gen.sv
module tb_dtile_addr_gen;
  logic        clk = 1'b0;
  logic        rst;
  logic        pix_valid;
  logic [11:0] pix_x, pix_y;
  logic [15:0] pitch;
  logic        pix_sz, lin_en;
  logic        ofs_valid;
  logic [25:0] ofs;

  int n_checks = 0;
  int n_fail   = 0;
  logic [25:0] held;
  logic [25:0] first_ofs;

  always #5 clk = ~clk;

  dtile_addr_gen dut (
    .clk(clk), .rst(rst), .pix_valid(pix_valid), .pix_x(pix_x),
    .pix_y(pix_y), .pitch(pitch), .pix_sz(pix_sz), .lin_en(lin_en),
    .ofs_valid(ofs_valid), .ofs(ofs)
  );

  function automatic longint ref_ofs(longint x, longint y, longint p,
                                     bit sz4, bit lin);
    longint o, tpr, yy, b, bank;
    if (lin) begin
      o = x * (sz4 ? 4 : 2) + y * p;
    end else begin
      tpr  = sz4 ? (p >> 7) : (p >> 8);
      yy   = sz4 ? (y & 2047) : y;
      b    = (yy >> 4) * tpr + (x >> (sz4 ? 5 : 6));
      bank = (tpr % 2 == 1) ? (b & 1) : ((b & 1) ^ ((y >> 4) & 1));
      o = ((b >> 1) << 12) + (bank << 11) + (((y >> 2) & 3) << 9);
      if (sz4)
        o += (((x >> 2) & 1) << 8) + (((x >> 3) & 3) << 6) + (((y >> 1) & 1) << 5)
           + (((x >> 1) & 1) << 4) + ((y & 1) << 3) + ((x & 1) << 2);
      else
        o += (((x >> 3) & 1) << 8) + (((x >> 4) & 3) << 6) + (((x >> 2) & 1) << 5)
           + (((y >> 1) & 1) << 4) + (((x >> 1) & 1) << 3) + ((y & 1) << 2)
           + ((x & 1) << 1);
    end
    return o & ((64'd1 << 26) - 1);
  endfunction

  task automatic chk(string req, longint act, longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Apply one coordinate, then check both outputs 1 ns after the capturing edge.
  task automatic step(int x, int y, int p, bit sz4, bit lin, bit v);
    pix_x = 12'(x); pix_y = 12'(y); pitch = 16'(p);
    pix_sz = sz4; lin_en = lin; pix_valid = v;
    @(posedge clk); #1;
    chk("R2 valid", ofs_valid, v);
    if (v) begin
      if (lin) chk("R4 R5 linear", ofs, ref_ofs(x, y, p, sz4, 1'b1));
      else if (sz4) chk("R5 R6 R7 R8 R10 tiled4", ofs, ref_ofs(x, y, p, 1'b1, 1'b0));
      else chk("R5 R6 R7 R8 R9 tiled2", ofs, ref_ofs(x, y, p, 1'b0, 1'b0));
    end
  endtask

  initial begin
    #1500000;
    n_fail++; n_checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst = 1'b1; pix_valid = 1'b0; pix_x = '0; pix_y = '0;
    pitch = '0; pix_sz = 1'b0; lin_en = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    chk("R1 reset valid", ofs_valid, 0);
    chk("R1 reset ofs", ofs, 0);
    @(negedge clk); rst = 1'b0;

    // R8: even and odd tiles-per-row, crossing the 16-row boundary
    step(0,   16, 16'h200, 0, 0, 1);
    step(64,  16, 16'h300, 0, 0, 1);
    step(0,   16, 16'h100, 1, 0, 1);
    step(32,  16, 16'h180, 1, 0, 1);
    step(63,  15, 16'h200, 0, 0, 1);
    step(31,  15, 16'h100, 1, 0, 1);
    // R9 and R10 single-bit walks
    for (int i = 0; i < 12; i++) begin
      step(1 << i, 0, 16'h400, 0, 0, 1);
      step(0, 1 << i, 16'h400, 1, 0, 1);
    end
    // R10: y[11] has no effect for 4-byte pixels
    step(77, 12'h123, 16'h280, 1, 0, 1);
    first_ofs = ofs;
    step(77, 12'h923, 16'h280, 1, 0, 1);
    chk("R10 y11 ignored", ofs, first_ofs);
    // R4: linear, both sizes
    step(4095, 4095, 16'hFFFF, 0, 1, 1);
    step(4095, 4095, 16'hFFFF, 1, 1, 1);
    step(3, 2, 100, 1, 1, 1);
    // R3: idle cycles keep the offset
    held = ofs;
    step(500, 700, 16'h800, 0, 0, 0);
    chk("R3 hold", ofs, held);
    step(9, 9, 16'h800, 1, 1, 0);
    chk("R3 hold", ofs, held);

    for (int n = 0; n < 3000; n++) begin
      int p;
      p = (n % 4 == 0) ? (int'($urandom_range(1, 200)) << 8) :
          (n % 4 == 1) ? ((int'($urandom_range(0, 255)) << 8) | 8'h80) :
          int'($urandom_range(0, 65535));
      if (($urandom % 8) == 0) begin
        held = ofs;
        step(int'($urandom % 4096), int'($urandom % 4096), p, 1'($urandom), 1'($urandom), 0);
        chk("R3 hold random", ofs, held);
      end else begin
        step(int'($urandom % 4096), int'($urandom % 4096), p, 1'($urandom),
             (($urandom % 5) == 0), 1);
      end
    end

    // R1: reset in the middle of traffic
    step(100, 100, 16'h400, 0, 0, 1);
    rst = 1'b1; pix_valid = 1'b1;
    @(posedge clk); #1;
    chk("R1 mid reset valid", ofs_valid, 0);
    chk("R1 mid reset ofs", ofs, 0);
    rst = 1'b0;

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule